// File: doc/BRIEF.md
# Sampling Tap Sweep Sequencer

This block drives the phase sweep of a high-speed SD/eMMC receive-sampling delay line. On a start pulse it captures the number of delay taps offered by the delay line. It then walks through every tap twice. For each step it sets the tap position and raises a probe request toward an external tuning-block engine. It waits for that engine's acknowledge and pass/fail result. When the probe completes, it also samples a data-compare status word.

The result of each step lands in two vectors. One records whether the probe passed. The other records whether the compare word read zero. A later selection stage uses the two vectors to choose the final tap. Between probes the block pauses for one millisecond, counted in clock cycles from a clock-frequency parameter.

In three cases the block completes at once, with no sweep and no error: the bus is not in a high-speed mode, the tap count is zero, or the results would not fit in the vectors.

Top module: `tap_sweep_seq`

## Requirements
- R1: After reset, `pass_vec`, `match_vec` and `tap_sel` are zero, and `busy`, `done`, `ran` and `probe_req` are low.
- R2: A sweep with N taps performs exactly 2N probes. During probe i (counting from 0), `tap_sel` equals i mod N and holds steady while `probe_req` is high.
- R3: Bit i of `pass_vec` is 1 only when probe i ended with `probe_ack` high and `probe_ok` high. Bits at and above 2N are 0. Both vectors are cleared at each accepted start and change only while `busy` is high.
- R4: Bit i of `match_vec` is 1 exactly when `cmp_status` equals zero in the cycle that probe i completes, whether it completes by acknowledge or by timeout.
- R5: After each probe ends, `probe_req` stays low for exactly CLK_HZ/1000 cycles before the next probe is requested.
- R6: When `tap_count` is 0 at start, `done` pulses in the cycle after start, with `ran` low, and no probe is requested.
- R7: When 2×`tap_count` is VEC_W or more, the block behaves as in R6. With the default VEC_W of 32, N=16 is skipped and N=15 sweeps.
- R8: `bus_mode` encodes 0 = legacy speed and 1, 2, 3 = the three high-speed modes. When `bus_mode` is 0 at start, the block behaves as in R6.
- R9: `probe_req` stays high until `probe_ack` is seen or until PROBE_TO cycles have passed. A probe that times out is recorded as failed.
- R10: `busy` is high from the cycle after an accepted start until the sweep ends. At the end, `done` pulses for one cycle with `busy` low and `ran` high.
- R11: A start pulse while `busy` is high is ignored. The sweep in progress keeps its captured tap count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a sweep when the block is idle |
| bus_mode | input | 2 | Bus speed mode; 0 = legacy, 1 to 3 = high-speed |
| tap_count | input | TAP_W | Number of taps offered by the delay line |
| tap_sel | output | TAP_W | Tap position being probed |
| probe_req | output | 1 | Probe request, held until acknowledge or timeout |
| probe_ack | input | 1 | Probe completion from the tuning engine |
| probe_ok | input | 1 | Probe passed; valid with `probe_ack` |
| cmp_status | input | VEC_W | Data-compare status word; zero means match |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle completion pulse |
| ran | output | 1 | The last completion performed a sweep |
| pass_vec | output | VEC_W | Probe pass bit per step |
| match_vec | output | VEC_W | Compare match bit per step |

## Verification
The bench checks the wrap of the tap index at N. A design that used the step index directly would probe positions past the last tap on the second pass.

It drops acknowledges on chosen steps. This exposes a sequencer that hangs, that records a timed-out probe as a pass, or that leaves the compare bit unsampled.

It drives the three skip conditions, with N=16 against N=15 at the vector-width limit. An off-by-one in the size test would either overflow the vectors or refuse a legal sweep.

It also checks two further cases. It pokes start in mid-sweep, where a design that re-latched the tap count would change the probe count. It runs after a full sweep, where vectors that were not cleared would leak old bits into the new result.

// File: rtl/tap_sweep_seq.sv
module tap_sweep_seq #(
  parameter int CLK_HZ   = 200_000_000,
  parameter int VEC_W    = 32,
  parameter int TAP_W    = 8,
  parameter int PROBE_TO = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       bus_mode,
  input  logic [TAP_W-1:0] tap_count,
  output logic [TAP_W-1:0] tap_sel,
  output logic             probe_req,
  input  logic             probe_ack,
  input  logic             probe_ok,
  input  logic [VEC_W-1:0] cmp_status,
  output logic             busy,
  output logic             done,
  output logic             ran,
  output logic [VEC_W-1:0] pass_vec,
  output logic [VEC_W-1:0] match_vec
);
  localparam int WAIT_CYC = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
  localparam int WC_W     = $clog2(WAIT_CYC + 1);
  localparam int TO_W     = $clog2(PROBE_TO + 1);
  localparam int STEP_W   = $clog2(VEC_W);
  localparam logic [WC_W-1:0] W_LAST  = WC_W'(WAIT_CYC - 1);
  localparam logic [TO_W-1:0] TO_LAST = TO_W'(PROBE_TO - 1);

  typedef enum logic [1:0] {S_IDLE, S_PROBE, S_WAIT} state_t;
  state_t state;

  logic [TAP_W-1:0]  n_q;
  logic [STEP_W-1:0] step;
  logic [WC_W-1:0]   wcnt;
  logic [TO_W-1:0]   tcnt;

  logic [TAP_W:0] two_n_in, two_n_q;
  logic           skip, last_step, tap_wrap, probe_end;

  assign two_n_in  = {tap_count, 1'b0};
  assign two_n_q   = {n_q, 1'b0};
  assign skip      = (bus_mode == 2'd0) || (tap_count == '0) ||
                     (two_n_in >= (TAP_W+1)'(VEC_W));
  assign last_step = ((TAP_W+1)'(step) == two_n_q - 1'b1);
  assign tap_wrap  = (tap_sel == n_q - 1'b1);
  assign probe_end = probe_ack || (tcnt == TO_LAST);
  assign busy      = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      n_q       <= '0;
      step      <= '0;
      wcnt      <= '0;
      tcnt      <= '0;
      tap_sel   <= '0;
      probe_req <= 1'b0;
      done      <= 1'b0;
      ran       <= 1'b0;
      pass_vec  <= '0;
      match_vec <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          pass_vec  <= '0;
          match_vec <= '0;
          step      <= '0;
          wcnt      <= '0;
          tcnt      <= '0;
          tap_sel   <= '0;
          n_q       <= tap_count;
          if (skip) begin
            done <= 1'b1;
            ran  <= 1'b0;
          end else begin
            ran       <= 1'b1;
            probe_req <= 1'b1;
            state     <= S_PROBE;
          end
        end
        S_PROBE: begin
          if (probe_end) begin
            pass_vec[step]  <= probe_ack & probe_ok;
            match_vec[step] <= (cmp_status == '0);
            probe_req       <= 1'b0;
            wcnt            <= '0;
            state           <= S_WAIT;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_WAIT: begin
          if (wcnt == W_LAST) begin
            if (last_step) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              step      <= step + 1'b1;
              tap_sel   <= tap_wrap ? '0 : tap_sel + 1'b1;
              tcnt      <= '0;
              probe_req <= 1'b1;
              state     <= S_PROBE;
            end
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tap_sweep_seq_chk.sv
module tap_sweep_seq_chk #(
  parameter int VEC_W = 32,
  parameter int TAP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [TAP_W-1:0] tap_sel,
  input logic             probe_req,
  input logic             busy,
  input logic             done,
  input logic             ran,
  input logic [VEC_W-1:0] pass_vec,
  input logic [VEC_W-1:0] match_vec
);
  AST_REQ_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n) probe_req |-> busy); // R9
  AST_TAP_HELD: assert property (@(posedge clk) disable iff (!rst_n) (probe_req && $past(probe_req)) |-> $stable(tap_sel)); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R10
  AST_PASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> $stable(pass_vec)); // R3
  AST_MATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> $stable(match_vec)); // R4
  AST_SKIP_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n) (done && !ran) |-> !probe_req); // R6
endmodule

bind tap_sweep_seq tap_sweep_seq_chk #(.VEC_W(VEC_W), .TAP_W(TAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .tap_sel(tap_sel),
  .probe_req(probe_req), .busy(busy), .done(done), .ran(ran),
  .pass_vec(pass_vec), .match_vec(match_vec)
);

// File: tb/sim_tap_sweep_seq.sv
`timescale 1ns/1ps
module sim_tap_sweep_seq;
  localparam int CLK_HZ = 20_000;
  localparam int W      = CLK_HZ / 1000;
  localparam int PTO    = 12;
  localparam int DLY    = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  bus_mode = 2'd1;
  logic [7:0]  tap_count = 8'd0;
  logic [7:0]  tap_sel;
  logic        probe_req, probe_ack = 1'b0, probe_ok = 1'b0;
  logic [31:0] cmp_status = 32'h0;
  logic        busy, done, ran;
  logic [31:0] pass_vec, match_vec;

  tap_sweep_seq #(.CLK_HZ(CLK_HZ), .VEC_W(32), .TAP_W(8), .PROBE_TO(PTO)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_mode(bus_mode), .tap_count(tap_count),
    .tap_sel(tap_sel), .probe_req(probe_req), .probe_ack(probe_ack), .probe_ok(probe_ok),
    .cmp_status(cmp_status), .busy(busy), .done(done), .ran(ran),
    .pass_vec(pass_vec), .match_vec(match_vec));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // responder
  logic [31:0] okpat = '0, cmppat = '0, droppat = '0;
  int cur_n = 1, idx = 0, hcnt = 0, lcnt = 0, tap_err = 0, gap_err = 0, to_err = 0;
  bit prev_req = 0, gap_on = 0;
  always @(negedge clk) begin
    probe_ack <= 1'b0;
    if (probe_req && !prev_req) begin
      if (tap_sel != 8'(idx % cur_n)) tap_err++;
      if (gap_on && lcnt != W) gap_err++;
      gap_on = 0;
      hcnt = 0;
      cmp_status <= cmppat[idx] ? 32'h0 : 32'h0000_0104;
    end
    if (!probe_req && prev_req) begin
      if (droppat[idx] ? (hcnt != PTO) : (hcnt != DLY)) to_err++;
      idx++;
      gap_on = 1;
      lcnt = 0;
    end
    if (probe_req) begin
      hcnt++;
      if (!droppat[idx] && hcnt == DLY) begin
        probe_ack <= 1'b1;
        probe_ok  <= okpat[idx];
      end
    end else if (gap_on) lcnt++;
    prev_req = probe_req;
  end

  task automatic launch(input logic [1:0] m, input int n, input int poke_at, output int lat);
    int busy_err = 0;
    idx = 0; tap_err = 0; gap_err = 0; to_err = 0; gap_on = 0;
    cur_n = (n == 0) ? 1 : n;
    @(negedge clk);
    bus_mode = m; tap_count = 8'(n); start = 1'b1;
    lat = -1;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (k == 0) start = 1'b0;
      if (k == poke_at) begin tap_count = 8'd7; start = 1'b1; end
      if (k == poke_at + 1) begin tap_count = 8'(n); start = 1'b0; end
      if (done) begin lat = k; break; end
      if (!busy) busy_err++;
    end
    chk(busy_err == 0, "R10 busy through sweep", busy_err, 0);
    chk(!busy, "R10 busy low at done", busy, 0);
  endtask

  task automatic t_reset;
    chk(pass_vec == 0 && match_vec == 0, "R1 vectors", pass_vec ^ match_vec, 0);
    chk(tap_sel == 0, "R1 tap_sel", tap_sel, 0);
    chk({busy, done, ran, probe_req} == 4'b0, "R1 flags", {busy, done, ran, probe_req}, 0);
  endtask

  task automatic t_sweep(input logic [1:0] m, input int n, input logic [31:0] okp,
                         input logic [31:0] cmpp, input logic [31:0] drp, input int poke);
    int lat;
    logic [31:0] mask;
    okpat = okp; cmppat = cmpp; droppat = drp;
    mask = (2 * n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << (2 * n)) - 1);
    launch(m, n, poke, lat);
    chk(lat > 0, "R10 done seen", lat, 1);
    chk(ran, "R10 ran high", ran, 1);
    chk(idx == 2 * n, "R2 probe count", idx, 2 * n);
    chk(tap_err == 0, "R2 tap = step mod N", tap_err, 0);
    chk(pass_vec == (okp & ~drp & mask), "R3 pass_vec", pass_vec, okp & ~drp & mask);
    chk(match_vec == (cmpp & mask), "R4 match_vec", match_vec, cmpp & mask);
    chk(gap_err == 0, "R5 inter-probe wait", gap_err, 0);
    chk(to_err == 0, "R9 request length", to_err, 0);
  endtask

  task automatic t_skip(input logic [1:0] m, input int n, input string tag);
    int lat;
    launch(m, n, -5, lat);
    chk(lat == 0, {tag, " done next cycle"}, lat, 0);
    chk(!ran && idx == 0, {tag, " no sweep"}, {ran, 8'(idx)}, 0);
    chk(pass_vec == 0 && match_vec == 0, {tag, " vectors cleared"}, pass_vec | match_vec, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_sweep(2'd1, 4, 32'h0000_00B6, 32'h0000_003C, 32'h0, -5);
    t_sweep(2'd3, 5, 32'h0000_03FF, 32'h0000_0155, 32'h0000_0084, -5);   // R9 timeouts
    t_skip(2'd2, 0, "R6");
    t_sweep(2'd2, 3, 32'h0000_002D, 32'h0000_0012, 32'h0, 40);           // R11 poke
    t_skip(2'd1, 16, "R7");
    t_sweep(2'd1, 15, 32'h2AF0_F0F1, 32'h1234_5678, 32'h0, -5);           // R7 limit
    t_skip(2'd0, 4, "R8");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule